// File: doc/BRIEF.md
# Two-Stage Clock-Enable Divider with Stop Controls

This block turns a parent clock into two single-cycle enable streams. A first counter divides the parent clock by a power-of-two ratio chosen by a 3-bit source code and drives the intermediate (high-speed) enable. A second counter counts those intermediate ticks and divides them by two or four, chosen by a 2-bit final code, to drive the final enable. The overall ratio from the parent clock to the final enable is the product of the two stage ratios, from 2 up to 64.

A single 10-bit control register, written and read through a plain port, holds both codes and two stop bits. Each stop bit gates one output while the internal counters keep running, so the final enable still ticks while the intermediate one is gated. With both stop bits set, or with any code outside the legal set, both counters are held cleared and both outputs stay low. An illegal code also raises an error flag. Every register write restarts both counters, so the first pulses after a write always fall on a fixed cycle count.

Top module: `twostage_clkdiv`

## Requirements
- R1: After reset the register reads 0x301 (source code 0, final code 1, both stop bits set), `hs_en` and `fin_en` are low, `cfg_err` is low and `active` is low.
- R2: A write with `wr_en` high stores bit 9 (intermediate stop), bit 8 (final stop), bits 4:2 (source code) and bits 1:0 (final code); `rd_data` shows the new value in the cycle after the write edge, with bits 7:5 always reading 0.
- R3: Source codes 0, 1, 2, 3 and 4 make `hs_en` pulse once every 1, 2, 4, 8 and 16 parent cycles respectively.
- R4: Final code 0 makes `fin_en` pulse once every 2 intermediate ticks and final code 1 once every 4, so the `fin_en` period is the product of both ratios (2 to 64 cycles), and each `fin_en` pulse coincides with an intermediate tick.
- R5: After a write edge E0, the first `hs_en` pulse is high in the cycle after edge E0+R_src and the first `fin_en` pulse in the cycle after edge E0+R_src*R_fin, regardless of the counter phase before the write.
- R6: With bit 9 set and bit 8 clear, `hs_en` stays low while `fin_en` keeps its normal period.
- R7: With bit 8 set and bit 9 clear, `fin_en` stays low while `hs_en` keeps its normal period.
- R8: With both stop bits set, both outputs stay low.
- R9: A source code of 5 to 7 or a final code of 2 or 3 holds both outputs low and drives `cfg_err` high; writing a legal code drops `cfg_err` again.
- R10: `active` is high exactly when both stop bits read 0.
- R11: A single write that changes the codes and the stop bits together applies all of them from the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 10 | Register write value |
| rd_data | output | 10 | Current register value |
| hs_en | output | 1 | Intermediate enable pulse |
| fin_en | output | 1 | Final enable pulse |
| cfg_err | output | 1 | Illegal code combination held |
| active | output | 1 | Both stop bits clear |

## Verification
A register write and a due divider pulse can land in the same cycle: the write restarts both counters, so the pulse that was due must be dropped and the new phase must count from the write edge. Each scenario writes a new setting at whatever phase the previous one left, often mid-period, and the bench judges the outcome by the cycle index of the first pulse of each output and by every later pulse falling on a multiple of its expected period. A second overlap, a stop bit changing with the codes in one write, is judged by the absence of any pulse from the old setting.

// File: rtl/tsd_pkg.sv
`timescale 1ns/1ps
package tsd_pkg;
  localparam int REG_W        = 10;
  localparam int HS_STOP_BIT  = 9;
  localparam int FIN_STOP_BIT = 8;
  localparam int SRC_LSB      = 2;
  localparam int SRC_W        = 3;
  localparam int FIN_LSB      = 0;
  localparam int FIN_W        = 2;
  localparam int SRC_CODE_MAX = 4;
  localparam int FIN_CODE_MAX = 1;
  localparam int PRE_CNT_W    = SRC_CODE_MAX;
  localparam int POST_CNT_W   = 2;

  localparam logic [REG_W-1:0] RESET_VAL = 10'h301;

  typedef struct packed {
    logic             stop_hs;
    logic             stop_fin;
    logic [SRC_W-1:0] src;
    logic [FIN_W-1:0] fin;
  } cfg_t;

  // terminal count of the pre-divider: ratio 2**code, minus one
  function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [SRC_W-1:0] code);
    int r;
    r = (1 << code) - 1;
    return PRE_CNT_W'(r);
  endfunction

  // terminal count of the post-divider: code 0 -> /2, code 1 -> /4
  function automatic logic [POST_CNT_W-1:0] post_limit(input logic [FIN_W-1:0] code);
    return (code == '0) ? POST_CNT_W'(1) : POST_CNT_W'(3);
  endfunction
endpackage

// File: rtl/tsd_cfg_reg.sv
`timescale 1ns/1ps
module tsd_cfg_reg
  import tsd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cfg_t             cfg,
  output logic [REG_W-1:0] rd_data,
  output logic             legal
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.stop_hs  <= RESET_VAL[HS_STOP_BIT];
      cfg.stop_fin <= RESET_VAL[FIN_STOP_BIT];
      cfg.src      <= RESET_VAL[SRC_LSB +: SRC_W];
      cfg.fin      <= RESET_VAL[FIN_LSB +: FIN_W];
    end else if (wr_en) begin
      cfg.stop_hs  <= wr_data[HS_STOP_BIT];
      cfg.stop_fin <= wr_data[FIN_STOP_BIT];
      cfg.src      <= wr_data[SRC_LSB +: SRC_W];
      cfg.fin      <= wr_data[FIN_LSB +: FIN_W];
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[HS_STOP_BIT]         = cfg.stop_hs;
    rd_data[FIN_STOP_BIT]        = cfg.stop_fin;
    rd_data[SRC_LSB +: SRC_W]    = cfg.src;
    rd_data[FIN_LSB +: FIN_W]    = cfg.fin;
  end

  assign legal = (int'(cfg.src) <= SRC_CODE_MAX) && (int'(cfg.fin) <= FIN_CODE_MAX);
endmodule

// File: rtl/tsd_stage.sv
`timescale 1ns/1ps
module tsd_stage #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick_in,
  input  logic [CNT_W-1:0] limit,
  output logic             tick_out
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)      cnt <= '0;
    else if (tick_in) begin
      if (cnt == limit)       cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end

  assign tick_out = tick_in && !clear && (cnt == limit);
endmodule

// File: rtl/twostage_clkdiv.sv
`timescale 1ns/1ps
module twostage_clkdiv
  import tsd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             hs_en,
  output logic             fin_en,
  output logic             cfg_err,
  output logic             active
);
  cfg_t cfg;
  logic legal, run, clr, hs_tick, fin_tick;

  tsd_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .rd_data(rd_data), .legal(legal)
  );

  assign run = legal && !(cfg.stop_hs && cfg.stop_fin);
  assign clr = !run || wr_en;

  tsd_stage #(.CNT_W(PRE_CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(clr), .tick_in(run),
    .limit(pre_limit(cfg.src)), .tick_out(hs_tick)
  );

  tsd_stage #(.CNT_W(POST_CNT_W)) u_post (
    .clk(clk), .rst_n(rst_n), .clear(clr), .tick_in(hs_tick),
    .limit(post_limit(cfg.fin)), .tick_out(fin_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_en  <= 1'b0;
      fin_en <= 1'b0;
    end else begin
      hs_en  <= hs_tick  && !cfg.stop_hs;
      fin_en <= fin_tick && !cfg.stop_fin;
    end
  end

  assign cfg_err = !legal;
  assign active  = !cfg.stop_hs && !cfg.stop_fin;
endmodule

// File: rtl/twostage_clkdiv_chk.sv
`timescale 1ns/1ps
module twostage_clkdiv_chk
  import tsd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             hs_en,
  input logic             fin_en,
  input logic             cfg_err
);
  localparam logic [REG_W-1:0] RW_MASK = 10'h31F;

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & RW_MASK));

  // R6
  hs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> !rd_data[HS_STOP_BIT]);

  // R7
  fin_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_en |-> !rd_data[FIN_STOP_BIT]);

  // R8
  both_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[HS_STOP_BIT] && rd_data[FIN_STOP_BIT]) |-> (!hs_en && !fin_en));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!hs_en && !fin_en));
endmodule

bind twostage_clkdiv twostage_clkdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .hs_en(hs_en), .fin_en(fin_en), .cfg_err(cfg_err)
);

// File: tb/twostage_clkdiv_bench.sv
`timescale 1ns/1ps
module twostage_clkdiv_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] wr_data = '0;
  logic [9:0] rd_data;
  logic       hs_en, fin_en, cfg_err, active;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twostage_clkdiv u_twostage_clkdiv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .hs_en(hs_en), .fin_en(fin_en),
    .cfg_err(cfg_err), .active(active)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [9:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Writes a setting, then observes n cycles; pulse k is sampled after edge E0+k.
  task automatic run_cfg(input string req, input int src, input int fin,
                         input bit shs, input bit sfin, input int n);
    int php, pfp, hs_cnt, fin_cnt, hs_first, fin_first, bad, exp_hs, exp_fin;
    php = 1 << src;
    pfp = php * ((fin == 1) ? 4 : 2);
    write_reg({shs, sfin, 3'b000, src[2:0], fin[1:0]});
    hs_cnt = 0; fin_cnt = 0; hs_first = 0; fin_first = 0; bad = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (hs_en) begin
        hs_cnt++;
        if (hs_first == 0) hs_first = k;
        if (k % php != 0) bad++;
      end
      if (fin_en) begin
        fin_cnt++;
        if (fin_first == 0) fin_first = k;
        if (k % pfp != 0) bad++;
      end
    end
    exp_hs  = (shs  || (shs && sfin)) ? 0 : n / php;
    exp_fin = (sfin || (shs && sfin)) ? 0 : n / pfp;
    check(req, "hs pulse count", hs_cnt, exp_hs);
    check(req, "fin pulse count", fin_cnt, exp_fin);
    check(req, "misplaced pulses", bad, 0);
    if (exp_hs > 0)  check("R5", "first hs pulse cycle", hs_first, php);
    if (exp_fin > 0) check("R5", "first fin pulse cycle", fin_first, pfp);
    check("R10", "active", int'(active), int'(!shs && !sfin));
    check("R9", "cfg_err on legal code", int'(cfg_err), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "reset rd_data", int'(rd_data), 'h301);
    check("R1", "reset hs_en", int'(hs_en), 0);
    check("R1", "reset fin_en", int'(fin_en), 0);
    check("R1", "reset cfg_err", int'(cfg_err), 0);
    check("R1", "reset active", int'(active), 0);
  endtask

  task automatic t_readback;
    write_reg(10'h3FF);
    check("R2", "readback masks bits 7:5", int'(rd_data), 'h31F);
    write_reg(10'h0E5);
    check("R2", "readback second value", int'(rd_data), 'h005);
  endtask

  task automatic t_src_sweep;
    for (int s = 0; s <= 4; s++) run_cfg("R3", s, 1, 0, 0, 130);
  endtask

  task automatic t_fin_codes;
    for (int s = 0; s <= 4; s++) run_cfg("R4", s, 0, 0, 0, 70);
  endtask

  task automatic t_hs_stop;
    run_cfg("R6", 3, 1, 1, 0, 130);
    run_cfg("R6", 2, 0, 1, 0, 40);
  endtask

  task automatic t_fin_stop;
    run_cfg("R7", 1, 1, 0, 1, 40);
  endtask

  task automatic t_both_stop;
    run_cfg("R8", 0, 0, 1, 1, 40);
    run_cfg("R8", 4, 1, 1, 1, 130);
  endtask

  task automatic t_illegal;
    int hs_cnt, fin_cnt;
    logic [9:0] bad_vals [3] = '{10'h01D, 10'h002, 10'h017};
    for (int i = 0; i < 3; i++) begin
      write_reg(bad_vals[i]);
      hs_cnt = 0; fin_cnt = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (hs_en) hs_cnt++;
        if (fin_en) fin_cnt++;
      end
      check("R9", "cfg_err on illegal code", int'(cfg_err), 1);
      check("R9", "hs pulses on illegal code", hs_cnt, 0);
      check("R9", "fin pulses on illegal code", fin_cnt, 0);
    end
    run_cfg("R9", 0, 0, 0, 0, 20);
  endtask

  task automatic t_same_write;
    // running fast, then one write changes codes and stops together
    run_cfg("R11", 0, 0, 0, 0, 7);
    run_cfg("R11", 2, 1, 0, 1, 33);
    run_cfg("R11", 1, 0, 1, 0, 21);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_src_sweep();
    t_fin_codes();
    t_hs_stop();
    t_fin_stop();
    t_both_stop();
    t_illegal();
    t_same_write();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule